// File: doc/BRIEF.md
# Serial Flash Write-Guard

This block decides, for a serial NOR flash, whether a decoded instruction that could alter stored data or the status byte may run. An upstream decoder presents one event per instruction: its code, the target sector, the number of serial clocks counted while chip select was low, and, for a status write, the new status byte. One cycle later the block answers with a single accept or reject pulse. An accepted program, erase or status write is then in progress until the array sequencer raises a completion strobe. At that point the block applies its side effects.

The block holds a write-enable latch, a three-bit protection level, a status-lock bit and an in-progress flag, and shows them as a status byte. The protection level marks a top-aligned run of sectors as read-only, growing by powers of two. The status-lock bit, together with a low level on the write-protect pin, freezes the status byte against writes. After reset, a start-up delay must run out before any instruction is honoured.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Instruction codes are WREN=0, WRDI=1, WRSR=2, PP=3, SE=4, BE=5. Codes 6 and 7 are always rejected. In the cycle after `op_valid` is sampled, exactly one of `op_accept` and `op_reject` is high. Both are low in any cycle that follows a cycle without `op_valid`.
- R2: An accepted WREN sets the write-enable latch (status bit 1) in the same edge that raises `op_accept`. An accepted WRDI clears it at that edge.
- R3: WRSR, PP, SE and BE are rejected while the write-enable latch is clear.
- R4: WRSR, PP, SE and BE are rejected unless `op_bits` is nonzero and a multiple of eight.
- R5: The protection level P is held in status bits 4:2, with 128 sectors by default. P=0 protects nothing. P=7 protects every sector. Any other P protects the top NSECT>>(7-P) sectors. PP and SE aimed at a protected sector are rejected.
- R6: BE is accepted only when the protection level is 0.
- R7: WRSR is rejected when the status-lock bit (status bit 7) is 1 and `wp_n` is low. When the lock bit is 0, a low `wp_n` has no effect.
- R8: After reset is released, every instruction is rejected until PUW_CYC clock edges have passed. An instruction sampled at edge PUW_CYC+1 or later can be accepted.
- R9: While an accepted WRSR, PP, SE or BE is pending, `op_done` clears the write-enable latch and the in-progress flag (status bit 0). For WRSR it also copies `sr_wdata` bits 7 and 4:2, as captured at acceptance, into the status byte; all other status bits keep their values. `op_done` with nothing pending has no effect.
- R10: A rejected instruction leaves the whole status byte unchanged.
- R11: While status bit 0 is set, every new instruction is rejected.
- R12: Reset clears the status byte to 0x00 and drives both outcome pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| op_valid | input | 1 | Decoded instruction present this cycle |
| op_code | input | 3 | Instruction code (see R1) |
| op_sector | input | SECT_W | Target sector index for PP and SE |
| op_bits | input | CNT_W | Serial clocks counted while chip select was low |
| sr_wdata | input | 8 | New status byte for WRSR |
| op_done | input | 1 | Completion strobe from the array sequencer |
| wp_n | input | 1 | Write-protect pin, active low |
| op_accept | output | 1 | One-cycle pulse: instruction granted |
| op_reject | output | 1 | One-cycle pulse: instruction refused |
| status | output | 8 | {lock, 0, 0, level[2:0], wel, busy} |

## Verification
Every piece of internal state shows up on `status` within one edge, and it also steers the next decision. A latch that fails to self-clear would let a second program pass without a fresh WREN, and the bench would see that on the very next vector. A wrong level decode shows as a wrong outcome on the boundary sector just below or at the protected run. A timer that is off by one shows as a flipped outcome at edge PUW_CYC or PUW_CYC+1.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [2:0] OP_WREN = 3'd0;
  localparam logic [2:0] OP_WRDI = 3'd1;
  localparam logic [2:0] OP_WRSR = 3'd2;
  localparam logic [2:0] OP_PP   = 3'd3;
  localparam logic [2:0] OP_SE   = 3'd4;
  localparam logic [2:0] OP_BE   = 3'd5;

  // status byte layout
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_LVL  = 2;
  localparam int ST_LOCK = 7;
  localparam logic [7:0] WRSR_MASK = 8'b1001_1100;

  function automatic logic is_modify(input logic [2:0] c);
    return (c == OP_WRSR) || (c == OP_PP) || (c == OP_SE) || (c == OP_BE);
  endfunction
endpackage

// File: rtl/wp_pup_timer.sv
module wp_pup_timer #(
  parameter int PUW_CYC = 16,
  localparam int CW = $clog2(PUW_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam logic [CW-1:0] LIM = CW'(PUW_CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIM);
endmodule

// File: rtl/wp_sector_guard.sv
module wp_sector_guard #(
  parameter int NSECT = 128,
  localparam int SECT_W = $clog2(NSECT)
) (
  input  logic [2:0]        level,
  input  logic [SECT_W-1:0] sector,
  output logic              prot
);
  localparam logic [SECT_W:0] NS = (SECT_W + 1)'(NSECT);
  logic [SECT_W:0] span;
  logic [SECT_W:0] base;

  always_comb begin
    span = NS >> (3'd7 - level);
    base = NS - span;
    case (level)
      3'd0:    prot = 1'b0;
      3'd7:    prot = 1'b1;
      default: prot = ({1'b0, sector} >= base);
    endcase
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import flash_wp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       code,
  input  logic [CNT_W-1:0] nbits,
  input  logic             ready,
  input  logic             busy,
  input  logic             wel,
  input  logic             lock,
  input  logic             wp_n,
  input  logic             sect_prot,
  input  logic [2:0]       level,
  output logic             grant
);
  logic frame_ok;
  logic g;

  always_comb begin
    frame_ok = (nbits[2:0] == 3'd0) && (|nbits);
    case (code)
      OP_WREN, OP_WRDI: g = 1'b1;
      OP_WRSR:          g = wel && frame_ok && !(lock && !wp_n);
      OP_PP, OP_SE:     g = wel && frame_ok && !sect_prot;
      OP_BE:            g = wel && frame_ok && (level == 3'd0);
      default:          g = 1'b0;
    endcase
    grant = ready && !busy && g;
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int NSECT   = 128,
  parameter int CNT_W   = 16,
  parameter int PUW_CYC = 16,
  localparam int SECT_W = $clog2(NSECT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [SECT_W-1:0] op_sector,
  input  logic [CNT_W-1:0]  op_bits,
  input  logic [7:0]        sr_wdata,
  input  logic              op_done,
  input  logic              wp_n,
  output logic              op_accept,
  output logic              op_reject,
  output logic [7:0]        status
);
  logic [7:0] st_q;
  logic [7:0] pend_data;
  logic       pend_wrsr;
  logic       ready;
  logic       prot;
  logic       grant;

  wp_pup_timer #(.PUW_CYC(PUW_CYC)) u_timer (
    .clk(clk), .rst(rst), .ready(ready)
  );

  wp_sector_guard #(.NSECT(NSECT)) u_guard (
    .level(st_q[ST_LVL +: 3]), .sector(op_sector), .prot(prot)
  );

  wp_gate #(.CNT_W(CNT_W)) u_gate (
    .code(op_code), .nbits(op_bits), .ready(ready),
    .busy(st_q[ST_BUSY]), .wel(st_q[ST_WEL]), .lock(st_q[ST_LOCK]),
    .wp_n(wp_n), .sect_prot(prot), .level(st_q[ST_LVL +: 3]),
    .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= 8'h00;
      pend_data <= 8'h00;
      pend_wrsr <= 1'b0;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
    end else begin
      op_accept <= 1'b0;
      op_reject <= 1'b0;
      if (op_done && st_q[ST_BUSY]) begin
        st_q[ST_BUSY] <= 1'b0;
        st_q[ST_WEL]  <= 1'b0;
        if (pend_wrsr)
          st_q[7:2] <= (st_q[7:2] & ~WRSR_MASK[7:2]) | (pend_data[7:2] & WRSR_MASK[7:2]);
      end
      if (op_valid) begin
        if (grant) begin
          op_accept <= 1'b1;
          case (op_code)
            OP_WREN: st_q[ST_WEL] <= 1'b1;
            OP_WRDI: st_q[ST_WEL] <= 1'b0;
            default: begin
              st_q[ST_BUSY] <= 1'b1;
              pend_wrsr     <= (op_code == OP_WRSR);
              pend_data     <= sr_wdata;
            end
          endcase
        end else begin
          op_reject <= 1'b1;
        end
      end
    end
  end

  assign status = st_q;
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk
  import flash_wp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PUW_CYC = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [CNT_W-1:0] op_bits,
  input logic             op_done,
  input logic             wp_n,
  input logic             op_accept,
  input logic             op_reject,
  input logic [7:0]       status
);
  int unsigned up;
  always_ff @(posedge clk) begin
    if (rst) up <= 0;
    else if (up < PUW_CYC) up <= up + 1;
  end

  p_one_outcome_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (op_accept ^ op_reject));
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !(op_accept || op_reject));
  p_wren_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (op_accept && $past(op_code) == OP_WREN) |-> status[ST_WEL]);
  p_wel_needed_r3: assert property (@(posedge clk) disable iff (rst)
    (op_accept && is_modify($past(op_code))) |-> $past(status[ST_WEL]));
  p_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (op_accept && is_modify($past(op_code))) |-> ($past(op_bits[2:0]) == 3'd0));
  p_bulk_r6: assert property (@(posedge clk) disable iff (rst)
    (op_accept && $past(op_code) == OP_BE) |-> ($past(status[4:2]) == 3'd0));
  p_hw_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (op_accept && $past(op_code) == OP_WRSR) |-> !($past(status[ST_LOCK]) && !$past(wp_n)));
  p_startup_r8: assert property (@(posedge clk) disable iff (rst)
    op_accept |-> ($past(up) >= PUW_CYC));
  p_reject_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (op_reject && !$past(op_done)) |-> (status == $past(status)));
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    op_accept |-> !$past(status[ST_BUSY]));
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.CNT_W(CNT_W), .PUW_CYC(PUW_CYC)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_bits(op_bits), .op_done(op_done), .wp_n(wp_n),
  .op_accept(op_accept), .op_reject(op_reject), .status(status)
);

// File: tb/flash_wp_ctrl_tb.sv
`timescale 1ns/100ps
module flash_wp_ctrl_tb;
  localparam int PUW = 16;
  localparam int NV  = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [6:0] op_sector = 7'd0;
  logic [15:0] op_bits = 16'd0;
  logic [7:0] sr_wdata = 8'h00;
  logic op_done = 1'b0;
  logic wp_n = 1'b1;
  logic op_accept, op_reject;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.NSECT(128), .CNT_W(16), .PUW_CYC(PUW)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_sector(op_sector), .op_bits(op_bits), .sr_wdata(sr_wdata),
    .op_done(op_done), .wp_n(wp_n), .op_accept(op_accept),
    .op_reject(op_reject), .status(status)
  );

  // {code[44:42], sector[41:35], bits[34:19], wp_n[18], data[17:10], acc[9], done[8], status[7:0]}
  localparam logic [44:0] VEC [NV] = '{
    {3'd3, 7'd0,   16'd32, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00}, // R3 no latch
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h02}, // R2
    {3'd3, 7'd0,   16'd33, 1'b1, 8'h00, 1'b0, 1'b0, 8'h02}, // R4
    {3'd3, 7'd0,   16'd40, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00}, // R9
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h02},
    {3'd5, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b1, 8'h00}, // R6
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h02},
    {3'd2, 7'd0,   16'd16, 1'b1, 8'hE7, 1'b1, 1'b1, 8'h84}, // R9 mask
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h86},
    {3'd4, 7'd126, 16'd32, 1'b1, 8'h00, 1'b0, 1'b0, 8'h86}, // R5
    {3'd4, 7'd125, 16'd32, 1'b1, 8'h00, 1'b1, 1'b1, 8'h84}, // R5
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h86},
    {3'd5, 7'd0,   16'd8,  1'b1, 8'h00, 1'b0, 1'b0, 8'h86}, // R6
    {3'd2, 7'd0,   16'd16, 1'b0, 8'h00, 1'b0, 1'b0, 8'h86}, // R7
    {3'd2, 7'd0,   16'd16, 1'b1, 8'h18, 1'b1, 1'b1, 8'h18}, // R7
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h1A},
    {3'd3, 7'd64,  16'd40, 1'b1, 8'h00, 1'b0, 1'b0, 8'h1A}, // R5
    {3'd3, 7'd63,  16'd40, 1'b1, 8'h00, 1'b1, 1'b1, 8'h18}, // R5
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h1A},
    {3'd1, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h18}, // R2
    {3'd7, 7'd0,   16'd8,  1'b1, 8'h00, 1'b0, 1'b0, 8'h18}, // R1
    {3'd2, 7'd0,   16'd16, 1'b1, 8'h00, 1'b0, 1'b0, 8'h18}, // R3
    {3'd0, 7'd0,   16'd8,  1'b1, 8'h00, 1'b1, 1'b0, 8'h1A},
    {3'd2, 7'd0,   16'd15, 1'b1, 8'h00, 1'b0, 1'b0, 8'h1A}, // R4
    {3'd2, 7'd0,   16'd16, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}  // R7 unlocked
  };

  function automatic string vtag(input int i);
    case (i)
      0, 21:          return "R3";
      1, 4, 6, 8, 11, 15, 18, 19, 22: return "R2";
      2, 23:          return "R4";
      3, 7:           return "R9";
      5, 12:          return "R6";
      9, 10, 16, 17:  return "R5";
      13, 14, 24:     return "R7";
      default:        return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // entered at a falling edge; returns at a falling edge with the op finished
  task automatic run_op(input logic [2:0] c, input logic [6:0] s, input logic [15:0] b,
                        input logic w, input logic [7:0] d, input logic done,
                        input logic exp_acc, input logic [7:0] exp_st, input string tag);
    op_valid = 1'b1; op_code = c; op_sector = s; op_bits = b; wp_n = w; sr_wdata = d;
    @(negedge clk);
    check({tag, " outcome"}, {6'd0, op_accept, op_reject}, {6'd0, exp_acc, !exp_acc});
    op_valid = 1'b0; wp_n = 1'b1;
    op_done = done;
    @(negedge clk);
    op_done = 1'b0;
    check({tag, " status"}, status, exp_st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 status", status, 8'h00);
    check("R12 pulses", {6'd0, op_accept, op_reject}, 8'h00);
    rst = 1'b0;
    // R8: sampled at edge PUW must be refused, at edge PUW+1 granted
    repeat (PUW - 1) @(negedge clk);
    op_valid = 1'b1; op_code = 3'd0; op_bits = 16'd8;
    @(negedge clk);
    check("R8 early", {6'd0, op_accept, op_reject}, 8'h01);
    check("R8 early status", status, 8'h00);
    @(negedge clk);
    check("R8 ready", {6'd0, op_accept, op_reject}, 8'h02);
    op_valid = 1'b0;
    @(negedge clk);
    check("R1 idle", {6'd0, op_accept, op_reject}, 8'h00);
    run_op(3'd1, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, "R2");

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][44:42], VEC[i][41:35], VEC[i][34:19], VEC[i][18], VEC[i][17:10],
             VEC[i][8], VEC[i][9], VEC[i][7:0], vtag(i));
    end

    // R11 / R10: in-progress lockout
    run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h02, "R2");
    run_op(3'd3, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h03, "R11");
    run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b0, 8'h03, "R10");
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    check("R9 done", status, 8'h00);
    // R9: stray strobe with nothing pending
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    @(negedge clk);
    check("R9 stray", status, 8'h00);
    // R4: zero count refused
    run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h02, "R2");
    run_op(3'd4, 7'd0, 16'd0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h02, "R4");
    run_op(3'd1, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, "R2");

    // R5: boundary of every protection level
    for (int p = 1; p < 8; p++) begin
      automatic int base = 128 - (128 >> (7 - p));
      automatic logic [7:0] lv = 8'(p << 2);
      run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h02, "R2");
      run_op(3'd2, 7'd0, 16'd16, 1'b1, lv, 1'b1, 1'b1, lv, "R5 level");
      run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, lv | 8'h02, "R2");
      if (base > 0) begin
        run_op(3'd4, 7'(base - 1), 16'd32, 1'b1, 8'h00, 1'b1, 1'b1, lv, "R5 below");
        run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, lv | 8'h02, "R2");
      end
      run_op(3'd4, 7'(base), 16'd32, 1'b1, 8'h00, 1'b0, 1'b0, lv | 8'h02, "R5 at");
      run_op(3'd2, 7'd0, 16'd16, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, "R5 clear");
    end

    // R12: reset mid-run clears everything
    run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b1, 8'h02, "R2");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 rerun", status, 8'h00);
    run_op(3'd0, 7'd0, 16'd8, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R8");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule